// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block steps an 8-bit processor core through its subroutine linkage instructions one clock per T-state. When the decoder raises a call or return request, the sequencer runs the complete set of machine cycles for that instruction on a simple synchronous byte bus. The bus has a registered address, write data, read data, and single-cycle read and write strobes. The sequencer also keeps the 16-bit program counter and stack pointer.

A call first fetches its opcode in a stretched 6 T-state cycle. It then reads the two target bytes that follow the opcode, low byte first. Next it pushes the address of the byte after the 3-byte instruction onto a stack that grows downward, and finally jumps. A return fetches its opcode in 4 T-states and pops the saved address back into the program counter. The stack pointer always names the next free slot. A push therefore stores at the stack pointer and then decrements it. A pop increments the stack pointer and then reads.

Top module: `callseq_top`

## Requirements
- R1: Out of reset, `pc` equals the parameter RESET_PC and `sp` equals RESET_SP. `busy`, `done`, `memRd` and `memWr` are 0, and `mCycle` and `tState` are 0.
- R2: A call is accepted on the clock edge that samples `reqCall` high while idle. It lasts 18 T-states, one clock each. M1 has 6 T-states and M2 to M5 have 3 each. `mCycle` counts from 1 and `tState` counts from 1 within each machine cycle.
- R3: A return accepted while idle lasts 10 T-states. Its M1 has 4 T-states and M2 and M3 have 3 each.
- R4: In every machine cycle, `memAddr` is loaded on entry to T1 and held through the cycle. Exactly one of `memRd` or `memWr` is high, and only in T2. The bus transfer takes place on the edge that ends T2.
- R5: The bus order of a call is as follows. It reads at pc, then at pc+1 (target low byte), then at pc+2 (target high byte). It then writes the high byte of pc+3 at sp, and the low byte of pc+3 at sp-1.
- R6: When a call completes, `pc` holds the target and `sp` is 2 below its start value. When a return completes, `pc` holds the popped address and `sp` is 2 above its start value. In both cases these values are present in the `done` cycle and remain unchanged afterwards.
- R7: A return reads at pc, then at sp+1 (low byte), then at sp+2 (high byte).
- R8: Requests raised while busy are ignored. If `reqCall` and `reqRet` are high together while idle, a call runs.
- R9: All address arithmetic on pc and sp wraps modulo 65536. A call at 0xFFFD saves the return address 0x0000.
- R10: `done` is a one-cycle pulse in the last T-state. `busy` is high from T1 through the `done` cycle and is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqCall | input | 1 | Decoded call request |
| reqRet | input | 1 | Decoded return request |
| memAddr | output | 16 | Bus address, registered |
| memWdata | output | 8 | Bus write data |
| memRdata | input | 8 | Bus read data, sampled at the end of T2 |
| memRd | output | 1 | Read strobe (T2 only) |
| memWr | output | 1 | Write strobe (T2 only) |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer, next free slot |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last T-state pulse |
| mCycle | output | 3 | Current machine cycle, 1-based, 0 when idle |
| tState | output | 3 | Current T-state, 1-based, 0 when idle |

## Verification
The bench goes after the pushed byte order and the pop order. A design that swapped them would show up as a wrong write address, a wrong memory byte, or a byte-reversed return PC. It counts the T-states of each instruction, so a stretched or shortened opcode fetch fails the 18-cycle or 10-cycle count. A request raised in the middle of an instruction and a simultaneous call and return request check that nothing restarts and that calls win. A call placed at 0xFFFD checks that the return address wraps to 0x0000 rather than carrying into a wider value.

// File: rtl/callseq_pkg.sv
package callseq_pkg;

  typedef enum logic [2:0] {
    ASEL_PC   = 3'd0,
    ASEL_PC1  = 3'd1,
    ASEL_PC2  = 3'd2,
    ASEL_SP   = 3'd3,
    ASEL_SPUP = 3'd4
  } addrSel_e;

  typedef struct packed {
    logic     latchAddr;
    addrSel_e addrSel;
    logic     rdStb;
    logic     wrStb;
    logic     wrHigh;
    logic     capTgtLo;
    logic     capTgtHi;
    logic     capPopLo;
    logic     spDec;
    logic     spInc;
    logic     pcFromTgt;
    logic     pcFromPop;
  } ctlStrobe_t;

  localparam int unsigned FETCH_T_CALL = 6;
  localparam int unsigned FETCH_T_RET  = 4;
  localparam int unsigned MEM_T        = 3;
  localparam int unsigned CALL_MCYC    = 5;
  localparam int unsigned RET_MCYC     = 3;
  localparam int unsigned CNT_W        = 3;

endpackage

// File: rtl/callseq_ctrl.sv
module callseq_ctrl
  import callseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqCall,
  input  logic             reqRet,
  output ctlStrobe_t       ctl,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] mCycle,
  output logic [CNT_W-1:0] tState
);

  localparam logic [CNT_W-1:0] T_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] T_XFER  = CNT_W'(2);
  localparam logic [CNT_W-1:0] T_MEM   = CNT_W'(MEM_T);
  localparam logic [CNT_W-1:0] T_FCALL = CNT_W'(FETCH_T_CALL);
  localparam logic [CNT_W-1:0] T_FRET  = CNT_W'(FETCH_T_RET);
  localparam logic [CNT_W-1:0] M_LCALL = CNT_W'(CALL_MCYC - 1);
  localparam logic [CNT_W-1:0] M_LRET  = CNT_W'(RET_MCYC - 1);

  logic             running, isCall;
  logic [CNT_W-1:0] mIdx, tIdx;
  logic             nRun, nCall;
  logic [CNT_W-1:0] nM, nT;
  logic [CNT_W-1:0] lastT, lastM;
  logic             inXfer;

  assign lastT = (mIdx == '0) ? (isCall ? T_FCALL : T_FRET) : T_MEM;
  assign lastM = isCall ? M_LCALL : M_LRET;
  assign done  = running && (mIdx == lastM) && (tIdx == lastT);
  assign busy  = running;
  assign mCycle = running ? mIdx + T_ONE : '0;
  assign tState = running ? tIdx : '0;

  always_comb begin
    nRun  = running;
    nCall = isCall;
    nM    = mIdx;
    nT    = tIdx;
    if (!running) begin
      if (reqCall || reqRet) begin
        nRun  = 1'b1;
        nCall = reqCall;
        nM    = '0;
        nT    = T_ONE;
      end
    end else if (tIdx == lastT) begin
      if (mIdx == lastM) begin
        nRun = 1'b0;
        nM   = '0;
        nT   = '0;
      end else begin
        nM = mIdx + T_ONE;
        nT = T_ONE;
      end
    end else begin
      nT = tIdx + T_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      isCall  <= 1'b0;
      mIdx    <= '0;
      tIdx    <= '0;
    end else begin
      running <= nRun;
      isCall  <= nCall;
      mIdx    <= nM;
      tIdx    <= nT;
    end
  end

  assign inXfer = running && (tIdx == T_XFER);

  always_comb begin
    ctl           = '0;
    ctl.addrSel   = ASEL_PC;
    ctl.latchAddr = nRun && (nT == T_ONE);
    if (nM != '0) begin
      if (nCall) begin
        case (nM)
          CNT_W'(1): ctl.addrSel = ASEL_PC1;
          CNT_W'(2): ctl.addrSel = ASEL_PC2;
          default:   ctl.addrSel = ASEL_SP;
        endcase
      end else begin
        ctl.addrSel = ASEL_SPUP;
      end
    end
    ctl.rdStb     = inXfer && (mIdx <= CNT_W'(2));
    ctl.wrStb     = inXfer && isCall && (mIdx >= CNT_W'(3));
    ctl.wrHigh    = (mIdx == CNT_W'(3));
    ctl.capTgtLo  = inXfer && isCall && (mIdx == CNT_W'(1));
    ctl.capTgtHi  = inXfer && isCall && (mIdx == CNT_W'(2));
    ctl.spDec     = ctl.wrStb;
    ctl.pcFromTgt = ctl.wrStb && (mIdx == M_LCALL);
    ctl.capPopLo  = inXfer && !isCall && (mIdx == CNT_W'(1));
    ctl.spInc     = inXfer && !isCall && (mIdx >= CNT_W'(1));
    ctl.pcFromPop = inXfer && !isCall && (mIdx == M_LRET);
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_exclusive_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rdStb && ctl.wrStb));
  a_r4_strobe_in_t2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdStb || ctl.wrStb) |-> (tState == T_XFER));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy && !(mCycle == T_ONE && tState == T_ONE)));

endmodule

// File: rtl/callseq_dp.sv
module callseq_dp
  import callseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);

  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] INSTR = ADDR_W'(3);

  logic [ADDR_W-1:0] addrQ, addrNext, retAddr;
  logic [DATA_W-1:0] tgtLo, tgtHi, popLo;

  assign retAddr = pc + INSTR;

  always_comb begin
    case (ctl.addrSel)
      ASEL_PC1:  addrNext = pc + ONE;
      ASEL_PC2:  addrNext = pc + TWO;
      ASEL_SP:   addrNext = sp;
      ASEL_SPUP: addrNext = sp + ONE;
      default:   addrNext = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= RESET_PC;
      sp    <= RESET_SP;
      addrQ <= RESET_PC;
      tgtLo <= '0;
      tgtHi <= '0;
      popLo <= '0;
    end else begin
      if (ctl.latchAddr) addrQ <= addrNext;
      if (ctl.capTgtLo)  tgtLo <= memRdata;
      if (ctl.capTgtHi)  tgtHi <= memRdata;
      if (ctl.capPopLo)  popLo <= memRdata;
      if (ctl.spDec)     sp    <= sp - ONE;
      else if (ctl.spInc) sp   <= sp + ONE;
      if (ctl.pcFromTgt)      pc <= {tgtHi, tgtLo};
      else if (ctl.pcFromPop) pc <= {memRdata, popLo};
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = ctl.wrHigh ? retAddr[ADDR_W-1 -: DATA_W] : retAddr[DATA_W-1:0];

  a_r5_push_free_slot: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStb |-> (memAddr == sp));
  a_r7_pop_above_sp: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spInc |-> (memAddr == sp + ONE));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdStb || ctl.wrStb) |-> $stable(memAddr));

endmodule

// File: rtl/callseq_top.sv
module callseq_top
  import callseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0100,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h0FF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqCall,
  input  logic              reqRet,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  mCycle,
  output logic [CNT_W-1:0]  tState
);

  ctlStrobe_t ctl;

  callseq_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqCall (reqCall),
    .reqRet  (reqRet),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .mCycle  (mCycle),
    .tState  (tState)
  );

  callseq_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .pc       (pc),
    .sp       (sp)
  );

  assign memRd = ctl.rdStb;
  assign memWr = ctl.wrStb;

  a_r6_settled: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(pc) && $stable(sp)));

endmodule

// File: tb/tb_callseq_top.sv
module tb_callseq_top;

  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic        isWr;
    logic [15:0] addr;
    logic [7:0]  data;
  } busEv_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqCall = 1'b0, reqRet = 1'b0;
  logic [15:0] memAddr, pc, sp;
  logic [7:0]  memWdata, memRdata;
  logic        memRd, memWr, busy, done;
  logic [2:0]  mCycle, tState;

  logic [7:0]  mem [0:4095];
  logic        pokeEn = 1'b0;
  logic [15:0] pokeAddr = '0;
  logic [7:0]  pokeData = '0;

  busEv_t      expQ[$];
  logic [15:0] retStack[$];
  logic [15:0] pcM, spM;
  int          nChecks = 0, nFail = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callseq_top dut (
    .clk(clk), .rstN(rstN), .reqCall(reqCall), .reqRet(reqRet),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memRd(memRd), .memWr(memWr), .pc(pc), .sp(sp),
    .busy(busy), .done(done), .mCycle(mCycle), .tState(tState)
  );

  assign memRdata = mem[memAddr[11:0]];

  always @(posedge clk) begin
    if (memWr) mem[memAddr[11:0]] <= memWdata;
    else if (pokeEn) mem[pokeAddr[11:0]] <= pokeData;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bus transfers as the design strobes
  always @(negedge clk) begin
    if (rstN && (memRd || memWr)) begin
      if (expQ.size() == 0) begin
        chk("R4", "unexpected bus transfer", {15'd0, memWr, memAddr}, 32'hFFFF_FFFF);
      end else begin
        busEv_t e;
        e = expQ.pop_front();
        chk(e.isWr ? "R5" : "R7", "transfer kind", {31'd0, memWr}, {31'd0, e.isWr});
        chk(e.isWr ? "R5" : "R7", "transfer address", {16'd0, memAddr}, {16'd0, e.addr});
        if (e.isWr) chk("R5", "pushed byte", {24'd0, memWdata}, {24'd0, e.data});
      end
    end
  end

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  // runs one instruction: kind 1 = call, 0 = return; both = raise both requests;
  // interfere = pulse the other request in T-state 5
  task automatic runOp(input bit kind, input bit both, input bit interfere);
    logic [15:0] ret, tgt, exPc, exSp;
    int cnt;
    string lr;
    lr = kind ? "R2" : "R3";
    if (kind) begin
      ret = pcM + 16'd3;
      tgt = {mem[12'(pcM + 16'd2)], mem[12'(pcM + 16'd1)]};
      expQ.push_back('{1'b0, pcM, 8'h00});
      expQ.push_back('{1'b0, pcM + 16'd1, 8'h00});
      expQ.push_back('{1'b0, pcM + 16'd2, 8'h00});
      expQ.push_back('{1'b1, spM, ret[15:8]});
      expQ.push_back('{1'b1, spM - 16'd1, ret[7:0]});
      exPc = tgt; exSp = spM - 16'd2;
    end else begin
      ret = '0;
      expQ.push_back('{1'b0, pcM, 8'h00});
      expQ.push_back('{1'b0, spM + 16'd1, 8'h00});
      expQ.push_back('{1'b0, spM + 16'd2, 8'h00});
      exPc = retStack.pop_back(); exSp = spM + 16'd2;
    end
    @(negedge clk);
    reqCall = kind | both; reqRet = ~kind | both;
    @(negedge clk);
    reqCall = 1'b0; reqRet = 1'b0;
    cnt = 1;
    chk("R10", "busy in T1", {31'd0, busy}, 32'd1);
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (interfere && cnt == 5) begin reqCall = ~kind; reqRet = kind; end
      if (interfere && cnt == 6) begin reqCall = 1'b0; reqRet = 1'b0; end
      if (cnt == (kind ? 6 : 4))
        chk(lr, "fetch last T-state", {26'd0, mCycle, tState}, {26'd0, 3'd1, kind ? 3'd6 : 3'd4});
      if (cnt == (kind ? 7 : 5))
        chk(lr, "M2 first T-state", {26'd0, mCycle, tState}, {26'd0, 3'd2, 3'd1});
    end
    chk(lr, "T-state count", cnt, kind ? 18 : 10);
    chk("R6", "pc at done", {16'd0, pc}, {16'd0, exPc});
    chk("R6", "sp at done", {16'd0, sp}, {16'd0, exSp});
    @(negedge clk);
    chk("R10", "busy after done", {31'd0, busy}, 32'd0);
    chk("R8", "no restart after done", {15'd0, done, pc}, {16'd0, exPc});
    @(negedge clk);
    chk("R8", "still idle", {31'd0, busy}, 32'd0);
    if (kind) begin
      chk("R5", "high byte in memory", {24'd0, mem[12'(spM)]}, {24'd0, ret[15:8]});
      chk("R5", "low byte in memory", {24'd0, mem[12'(spM - 16'd1)]}, {24'd0, ret[7:0]});
      retStack.push_back(ret);
    end
    chk("R4", "scoreboard drained", expQ.size(), 0);
    pcM = exPc; spM = exSp;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    pcM = 16'h0100; spM = 16'h0FF0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pc reset", {16'd0, pc}, 32'h0100);
    chk("R1", "sp reset", {16'd0, sp}, 32'h0FF0);
    chk("R1", "idle outputs", {26'd0, busy, done, memRd, memWr, mCycle == 0, tState == 0},
        {26'd0, 6'b000011});
    poke(16'h0101, 8'h00); poke(16'h0102, 8'h02);
    poke(16'h0201, 8'hFD); poke(16'h0202, 8'hFF);
    poke(16'hFFFE, 8'h00); poke(16'hFFFF, 8'h03);
    runOp(1'b1, 1'b0, 1'b1);  // R2 R8: call, return request mid-way ignored
    runOp(1'b1, 1'b1, 1'b0);  // R8: both requests, call wins
    runOp(1'b1, 1'b0, 1'b0);  // R9: call at 0xFFFD saves 0x0000
    chk("R9", "wrapped return address", {16'd0, retStack[retStack.size()-1]}, 32'h0000);
    runOp(1'b0, 1'b0, 1'b0);  // R3 R7: return to 0x0000
    chk("R9", "pc after wrapped return", {16'd0, pc}, 32'h0000);
    runOp(1'b0, 1'b0, 1'b1);  // R8: call request mid-return ignored
    runOp(1'b0, 1'b0, 1'b0);
    chk("R6", "final pc", {16'd0, pc}, 32'h0103);
    chk("R6", "final sp", {16'd0, sp}, 32'h0FF0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule